// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block decides, once per cycle, whether the instruction now in the execute stage of an in-order 32-bit pipeline takes a hardware trap. When a trap is accepted, the block does four things in that same cycle. It flushes the pipeline, kills the execute-stage instruction and points fetch at a fixed handler address. It also produces the value to write into the link register. At the following clock edge it records the trap cause, the delay-slot bit and the saved branch target, and it switches the machine-state bits into handler mode.

There are two classes of trap, and each sets the link value differently. For a memory-management fault, the link value makes the faulting instruction run again. If an immediate prefix or a branch (in the delay-slot case) comes before it, the link value backs up to that. For every other cause, the link value points at the next instruction. A delay-slot case is then marked in the status register and the branch target is kept. The three return kinds (from trap, from break and from interrupt) copy the saved mode bits back. Only the return from trap also re-enables traps.

Top module: `trap_sequencer`

## Requirements
- R1: A trap is accepted only when ex_valid_i is 1, at least one enabled fault input is 1, ee_o is 1 and eip_o is 0. In every other case the fault inputs are ignored: flush_o, ex_kill_o, redirect_valid_o and link_we_o stay 0, and no status bit changes.
- R2: In the cycle a trap is accepted, flush_o, ex_kill_o, redirect_valid_o and link_we_o are all 1, and redirect_pc_o equals VEC_BASE + 0x20.
- R3: For a cause that is not memory management, link_val_o equals ex_pc_i + 4, whether or not the instruction sits in a delay slot.
- R4: For a memory-management cause outside a delay slot, link_val_o is set as follows. It equals ex_pfx_pc_i when ex_pfx_i is 1. Otherwise it equals ex_pc_i.
- R5: For a memory-management cause in a delay slot, link_val_o is set as follows. It equals br_pfx_pc_i when br_pfx_i is 1. Otherwise it equals br_pc_i. After the edge, esr_ds_o is 0.
- R6: For a cause that is not memory management and that occurs in a delay slot, two things are true after the edge: esr_ds_o is 1 and btr_o holds the br_target_i value from the trap cycle. For any other accepted trap, esr_ds_o is 0 and btr_o keeps its value.
- R7: The fault inputs carry cause codes, and esr_cause_o takes the code of the trap accepted. The codes are: illegal 1, instruction bus 2, data bus 3, unaligned 4, divide 5, floating point 6, data storage 7, instruction storage 8, data TLB miss 9, instruction TLB miss 10. Codes 7 to 10 are the memory-management class. When several inputs are 1 at once, the lowest code wins.
- R8: After an accepted trap, the following hold: ums_o and vms_o equal the earlier um_o and vm_o, um_o and vm_o are 0, eip_o is 1 and ee_o is 0.
- R9: ret_kind_i = 1 (return from trap) does three things. It sets ee_o to 1, clears eip_o, and loads um_o/vm_o from ums_o/vms_o.
- R10: ret_kind_i = 2 (break) or 3 (interrupt) loads um_o/vm_o from ums_o/vms_o and leaves ee_o and eip_o unchanged.
- R11: When HAS_DIV is 0, the divide input never causes a trap. HAS_FPU gates the floating-point input in the same way, and HAS_MMU gates the four memory-management inputs.
- R12: When st_wr_i is 1, ee_o, um_o and vm_o are loaded from st_ee_i, st_um_i and st_vm_i. An accepted trap takes precedence over a return, and a return takes precedence over this write.
- R13: After reset, ee_o equals RESET_EE. eip_o, um_o, vm_o, ums_o, vms_o, esr_ds_o, esr_cause_o and btr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flt_illegal_i | input | 1 | Illegal opcode fault (code 1) |
| flt_ibus_i | input | 1 | Instruction bus error (code 2) |
| flt_dbus_i | input | 1 | Data bus error (code 3) |
| flt_unalign_i | input | 1 | Unaligned access (code 4) |
| flt_div_i | input | 1 | Divide fault (code 5) |
| flt_fpu_i | input | 1 | Floating-point fault (code 6) |
| flt_dstore_i | input | 1 | Data storage fault (code 7) |
| flt_istore_i | input | 1 | Instruction storage fault (code 8) |
| flt_dtlb_i | input | 1 | Data TLB miss (code 9) |
| flt_itlb_i | input | 1 | Instruction TLB miss (code 10) |
| ex_valid_i | input | 1 | Execute stage holds a valid instruction |
| ex_pc_i | input | ADDR_W | PC of the execute-stage instruction |
| ex_pfx_i | input | 1 | Immediate prefix precedes it |
| ex_pfx_pc_i | input | ADDR_W | PC of that prefix |
| ex_in_ds_i | input | 1 | Instruction sits in a branch delay slot |
| br_pc_i | input | ADDR_W | PC of the owning branch |
| br_pfx_i | input | 1 | Immediate prefix precedes the branch |
| br_pfx_pc_i | input | ADDR_W | PC of the branch's prefix |
| br_target_i | input | ADDR_W | Target address of the branch |
| ret_kind_i | input | 2 | 0 none, 1 trap return, 2 break return, 3 interrupt return |
| st_wr_i | input | 1 | Load state bits from st_* |
| st_ee_i | input | 1 | New trap-enable value |
| st_um_i | input | 1 | New user-mode value |
| st_vm_i | input | 1 | New virtual-mode value |
| flush_o | output | 1 | Flush the whole pipeline |
| ex_kill_o | output | 1 | Suppress writes of the execute-stage instruction |
| redirect_valid_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | ADDR_W | Handler address |
| link_we_o | output | 1 | Write link register |
| link_val_o | output | ADDR_W | Link register value |
| ee_o | output | 1 | Traps enabled |
| eip_o | output | 1 | Trap in progress |
| um_o | output | 1 | User mode |
| vm_o | output | 1 | Virtual mode |
| ums_o | output | 1 | Saved user mode |
| vms_o | output | 1 | Saved virtual mode |
| esr_cause_o | output | 4 | Cause code of last trap |
| esr_ds_o | output | 1 | Last trap was in a delay slot |
| btr_o | output | ADDR_W | Saved branch target |

## Verification
Corruption of the trap-in-progress or enable bit shows up immediately. A second fault is either accepted when it should be ignored, or dropped when it should be taken, and flush_o shows the error in that same cycle. A wrong class decision shows up at link_val_o in the trap cycle: the value is off by one instruction, or the backup to a prefix or branch is missing. The delay-slot bit and the saved target then show it one edge later. An error in the mode save or restore surfaces at um_o/vm_o one cycle after the entry or return. The directed scenarios chain entry, return and second entry, so that corruption in one step can be seen in the next.

// File: rtl/trap_pkg.sv
package trap_pkg;

   localparam int unsigned NUM_SRC = 10;
   localparam int unsigned CAUSE_W = 4;

   typedef enum logic [CAUSE_W-1:0] {
      CC_NONE    = 4'd0,
      CC_ILLEGAL = 4'd1,
      CC_IBUS    = 4'd2,
      CC_DBUS    = 4'd3,
      CC_UNALIGN = 4'd4,
      CC_DIV     = 4'd5,
      CC_FPU     = 4'd6,
      CC_DSTORE  = 4'd7,
      CC_ISTORE  = 4'd8,
      CC_DTLB    = 4'd9,
      CC_ITLB    = 4'd10
   } cause_e;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_EXC  = 2'd1,
      RK_BRK  = 2'd2,
      RK_INT  = 2'd3
   } ret_kind_e;

   typedef struct packed {
      logic ee;
      logic eip;
      logic um;
      logic vm;
      logic ums;
      logic vms;
   } mstat_t;

   // source index i maps to cause code i+1
   localparam int unsigned IDX_DIV       = 4;
   localparam int unsigned IDX_FPU       = 5;
   localparam int unsigned IDX_MMU_FIRST = 6;

   function automatic logic is_mmu_cause(cause_e c);
      return (c >= CC_DSTORE) && (c <= CC_ITLB);
   endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter bit HAS_DIV = 1'b1,
   parameter bit HAS_FPU = 1'b1,
   parameter bit HAS_MMU = 1'b1
) (
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               ex_valid_i,
   input  logic               ee_i,
   input  logic               eip_i,
   output logic               take_o,
   output cause_e             cause_o,
   output logic               mmu_o
);

   logic [NUM_SRC-1:0] enable_mask;
   logic [NUM_SRC-1:0] live_req;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
      if (i == IDX_DIV) begin : g_div
         assign enable_mask[i] = HAS_DIV;
      end else if (i == IDX_FPU) begin : g_fpu
         assign enable_mask[i] = HAS_FPU;
      end else if (i >= IDX_MMU_FIRST) begin : g_mmu
         assign enable_mask[i] = HAS_MMU;
      end else begin : g_base
         assign enable_mask[i] = 1'b1;
      end
   end

   assign live_req = req_i & enable_mask;

   // lowest index (lowest code) wins
   always_comb begin
      cause_o = CC_NONE;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (live_req[i]) cause_o = cause_e'(i + 1);
      end
   end

   assign take_o = ex_valid_i && ee_i && !eip_i && (|live_req);
   assign mmu_o  = is_mmu_cause(cause_o);

endmodule

// File: rtl/trap_link_calc.sv
module trap_link_calc #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INSN_BYTES = 4
) (
   input  logic              mmu_i,
   input  logic [ADDR_W-1:0] ex_pc_i,
   input  logic              ex_pfx_i,
   input  logic [ADDR_W-1:0] ex_pfx_pc_i,
   input  logic              ex_in_ds_i,
   input  logic [ADDR_W-1:0] br_pc_i,
   input  logic              br_pfx_i,
   input  logic [ADDR_W-1:0] br_pfx_pc_i,
   output logic [ADDR_W-1:0] link_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

   logic [ADDR_W-1:0] replay_pc;
   logic [ADDR_W-1:0] next_pc;

   always_comb begin
      if (ex_in_ds_i) replay_pc = br_pfx_i ? br_pfx_pc_i : br_pc_i;
      else            replay_pc = ex_pfx_i ? ex_pfx_pc_i : ex_pc_i;
   end

   assign next_pc = ex_pc_i + STEP;
   assign link_o  = mmu_i ? replay_pc : next_pc;

endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
   import trap_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter bit          RESET_EE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              take_i,
   input  cause_e            cause_i,
   input  logic              mmu_i,
   input  logic              in_ds_i,
   input  logic [ADDR_W-1:0] br_target_i,
   input  ret_kind_e         ret_kind_i,
   input  logic              st_wr_i,
   input  logic              st_ee_i,
   input  logic              st_um_i,
   input  logic              st_vm_i,
   output mstat_t            mstat_o,
   output cause_e            esr_cause_o,
   output logic              esr_ds_o,
   output logic [ADDR_W-1:0] btr_o
);

   mstat_t            ms_q;
   cause_e            cause_q;
   logic              ds_q;
   logic [ADDR_W-1:0] btr_q;
   logic              ds_capture;

   assign ds_capture = in_ds_i && !mmu_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ms_q    <= '{ee: RESET_EE, default: 1'b0};
         cause_q <= CC_NONE;
         ds_q    <= 1'b0;
         btr_q   <= '0;
      end else if (take_i) begin
         ms_q.ums <= ms_q.um;
         ms_q.vms <= ms_q.vm;
         ms_q.um  <= 1'b0;
         ms_q.vm  <= 1'b0;
         ms_q.eip <= 1'b1;
         ms_q.ee  <= 1'b0;
         cause_q  <= cause_i;
         ds_q     <= ds_capture;
         if (ds_capture) btr_q <= br_target_i;
      end else if (ret_kind_i != RK_NONE) begin
         ms_q.um <= ms_q.ums;
         ms_q.vm <= ms_q.vms;
         if (ret_kind_i == RK_EXC) begin
            ms_q.ee  <= 1'b1;
            ms_q.eip <= 1'b0;
         end
      end else if (st_wr_i) begin
         ms_q.ee <= st_ee_i;
         ms_q.um <= st_um_i;
         ms_q.vm <= st_vm_i;
      end
   end

   assign mstat_o     = ms_q;
   assign esr_cause_o = cause_q;
   assign esr_ds_o    = ds_q;
   assign btr_o       = btr_q;

   // R8
   entry_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> (ms_q.eip && !ms_q.ee && !ms_q.um && !ms_q.vm));

   // R8
   entry_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> (ms_q.ums == $past(ms_q.um) && ms_q.vms == $past(ms_q.vm)));

   // R6
   ds_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && ds_capture) |=> (ds_q && btr_q == $past(br_target_i)));

   // R9
   trap_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!take_i && ret_kind_i == RK_EXC) |=> (ms_q.ee && !ms_q.eip));

   // R10
   other_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!take_i && (ret_kind_i == RK_BRK || ret_kind_i == RK_INT))
         |=> ($stable(ms_q.ee) && $stable(ms_q.eip) && ms_q.um == $past(ms_q.ums)));

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 32,
   parameter int unsigned        INSN_BYTES = 4,
   parameter logic [ADDR_W-1:0]  VEC_BASE   = '0,
   parameter bit                 HAS_DIV    = 1'b1,
   parameter bit                 HAS_FPU    = 1'b1,
   parameter bit                 HAS_MMU    = 1'b1,
   parameter bit                 RESET_EE   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              flt_illegal_i,
   input  logic              flt_ibus_i,
   input  logic              flt_dbus_i,
   input  logic              flt_unalign_i,
   input  logic              flt_div_i,
   input  logic              flt_fpu_i,
   input  logic              flt_dstore_i,
   input  logic              flt_istore_i,
   input  logic              flt_dtlb_i,
   input  logic              flt_itlb_i,
   input  logic              ex_valid_i,
   input  logic [ADDR_W-1:0] ex_pc_i,
   input  logic              ex_pfx_i,
   input  logic [ADDR_W-1:0] ex_pfx_pc_i,
   input  logic              ex_in_ds_i,
   input  logic [ADDR_W-1:0] br_pc_i,
   input  logic              br_pfx_i,
   input  logic [ADDR_W-1:0] br_pfx_pc_i,
   input  logic [ADDR_W-1:0] br_target_i,
   input  logic [1:0]        ret_kind_i,
   input  logic              st_wr_i,
   input  logic              st_ee_i,
   input  logic              st_um_i,
   input  logic              st_vm_i,
   output logic              flush_o,
   output logic              ex_kill_o,
   output logic              redirect_valid_o,
   output logic [ADDR_W-1:0] redirect_pc_o,
   output logic              link_we_o,
   output logic [ADDR_W-1:0] link_val_o,
   output logic              ee_o,
   output logic              eip_o,
   output logic              um_o,
   output logic              vm_o,
   output logic              ums_o,
   output logic              vms_o,
   output logic [3:0]        esr_cause_o,
   output logic              esr_ds_o,
   output logic [ADDR_W-1:0] btr_o
);

   localparam logic [ADDR_W-1:0] VEC_OFS  = ADDR_W'(32'h20);
   localparam logic [ADDR_W-1:0] TRAP_VEC = VEC_BASE + VEC_OFS;

   initial begin : param_chk
      assert (ADDR_W >= 16 && ADDR_W <= 64)
         else $error("trap_sequencer: ADDR_W out of range");
      assert (INSN_BYTES != 0 && (INSN_BYTES & (INSN_BYTES - 1)) == 0)
         else $error("trap_sequencer: INSN_BYTES must be a power of two");
   end

   logic [NUM_SRC-1:0] req_vec;
   logic               take;
   logic               mmu_class;
   cause_e             cause;
   mstat_t             mstat;
   cause_e             esr_cause;

   assign req_vec = {flt_itlb_i, flt_dtlb_i, flt_istore_i, flt_dstore_i, flt_fpu_i,
                     flt_div_i, flt_unalign_i, flt_dbus_i, flt_ibus_i, flt_illegal_i};

   trap_arbiter #(
      .HAS_DIV (HAS_DIV),
      .HAS_FPU (HAS_FPU),
      .HAS_MMU (HAS_MMU)
   ) arb_i (
      .req_i      (req_vec),
      .ex_valid_i (ex_valid_i),
      .ee_i       (mstat.ee),
      .eip_i      (mstat.eip),
      .take_o     (take),
      .cause_o    (cause),
      .mmu_o      (mmu_class)
   );

   trap_link_calc #(
      .ADDR_W     (ADDR_W),
      .INSN_BYTES (INSN_BYTES)
   ) link_i (
      .mmu_i       (mmu_class),
      .ex_pc_i     (ex_pc_i),
      .ex_pfx_i    (ex_pfx_i),
      .ex_pfx_pc_i (ex_pfx_pc_i),
      .ex_in_ds_i  (ex_in_ds_i),
      .br_pc_i     (br_pc_i),
      .br_pfx_i    (br_pfx_i),
      .br_pfx_pc_i (br_pfx_pc_i),
      .link_o      (link_val_o)
   );

   trap_state_regs #(
      .ADDR_W   (ADDR_W),
      .RESET_EE (RESET_EE)
   ) regs_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .take_i      (take),
      .cause_i     (cause),
      .mmu_i       (mmu_class),
      .in_ds_i     (ex_in_ds_i),
      .br_target_i (br_target_i),
      .ret_kind_i  (ret_kind_e'(ret_kind_i)),
      .st_wr_i     (st_wr_i),
      .st_ee_i     (st_ee_i),
      .st_um_i     (st_um_i),
      .st_vm_i     (st_vm_i),
      .mstat_o     (mstat),
      .esr_cause_o (esr_cause),
      .esr_ds_o    (esr_ds_o),
      .btr_o       (btr_o)
   );

   assign flush_o          = take;
   assign ex_kill_o        = take;
   assign redirect_valid_o = take;
   assign link_we_o        = take;
   assign redirect_pc_o    = TRAP_VEC;

   assign ee_o        = mstat.ee;
   assign eip_o       = mstat.eip;
   assign um_o        = mstat.um;
   assign vm_o        = mstat.vm;
   assign ums_o       = mstat.ums;
   assign vms_o       = mstat.vms;
   assign esr_cause_o = esr_cause;

   // R1
   accept_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> (ee_o && !eip_o && ex_valid_i));

   // R1
   no_reentry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |=> !flush_o);

   // R7
   cause_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |=> (esr_cause_o != 4'd0 && esr_cause_o <= 4'd10));

   // R11
   div_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!HAS_DIV && flush_o) |=> (esr_cause_o != 4'd5));

endmodule

// File: tb/trap_sequencer_tb_top.sv
module trap_sequencer_tb_top;

   localparam int unsigned       AW   = 32;
   localparam logic [AW-1:0]     VB   = 32'h1000_0000;
   localparam logic [AW-1:0]     VEC  = 32'h1000_0020;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [9:0]    flt = '0;
   logic          ex_valid = 1'b0;
   logic [AW-1:0] ex_pc = '0;
   logic          ex_pfx = 1'b0;
   logic [AW-1:0] ex_pfx_pc = '0;
   logic          ex_in_ds = 1'b0;
   logic [AW-1:0] br_pc = '0;
   logic          br_pfx = 1'b0;
   logic [AW-1:0] br_pfx_pc = '0;
   logic [AW-1:0] br_target = '0;
   logic [1:0]    ret_kind = 2'd0;
   logic          st_wr = 1'b0, st_ee = 1'b0, st_um = 1'b0, st_vm = 1'b0;

   logic          flush, kill, rd_valid, link_we;
   logic [AW-1:0] rd_pc, link_val, btr;
   logic          ee, eip, um, vm, ums, vms, esr_ds;
   logic [3:0]    esr_cause;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   trap_sequencer #(
      .ADDR_W (AW), .INSN_BYTES (4), .VEC_BASE (VB),
      .HAS_DIV (1'b0), .HAS_FPU (1'b1), .HAS_MMU (1'b1), .RESET_EE (1'b1)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .flt_illegal_i (flt[0]), .flt_ibus_i (flt[1]), .flt_dbus_i (flt[2]),
      .flt_unalign_i (flt[3]), .flt_div_i (flt[4]), .flt_fpu_i (flt[5]),
      .flt_dstore_i (flt[6]), .flt_istore_i (flt[7]), .flt_dtlb_i (flt[8]),
      .flt_itlb_i (flt[9]),
      .ex_valid_i (ex_valid), .ex_pc_i (ex_pc), .ex_pfx_i (ex_pfx),
      .ex_pfx_pc_i (ex_pfx_pc), .ex_in_ds_i (ex_in_ds), .br_pc_i (br_pc),
      .br_pfx_i (br_pfx), .br_pfx_pc_i (br_pfx_pc), .br_target_i (br_target),
      .ret_kind_i (ret_kind), .st_wr_i (st_wr), .st_ee_i (st_ee),
      .st_um_i (st_um), .st_vm_i (st_vm),
      .flush_o (flush), .ex_kill_o (kill), .redirect_valid_o (rd_valid),
      .redirect_pc_o (rd_pc), .link_we_o (link_we), .link_val_o (link_val),
      .ee_o (ee), .eip_o (eip), .um_o (um), .vm_o (vm), .ums_o (ums),
      .vms_o (vms), .esr_cause_o (esr_cause), .esr_ds_o (esr_ds), .btr_o (btr)
   );

   task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      flt = '0; ex_valid = 1'b0; ex_pfx = 1'b0; ex_in_ds = 1'b0; br_pfx = 1'b0;
      ret_kind = 2'd0; st_wr = 1'b0;
   endtask

   // drive a fault at a negedge; comb outputs checked 2 ns later
   task automatic fault(logic [9:0] f, logic [AW-1:0] pc, logic pfx, logic [AW-1:0] ppc,
                        logic ds, logic [AW-1:0] bpc, logic bpfx, logic [AW-1:0] bppc,
                        logic [AW-1:0] tgt);
      @(negedge clk);
      flt = f; ex_valid = 1'b1; ex_pc = pc; ex_pfx = pfx; ex_pfx_pc = ppc;
      ex_in_ds = ds; br_pc = bpc; br_pfx = bpfx; br_pfx_pc = bppc; br_target = tgt;
      #2;
   endtask

   task automatic settle();
      @(negedge clk);
      idle();
      #1;
   endtask

   task automatic do_ret(logic [1:0] k);
      @(negedge clk); ret_kind = k; settle();
   endtask

   task automatic do_wr(logic e, logic u, logic v);
      @(negedge clk); st_wr = 1'b1; st_ee = e; st_um = u; st_vm = v; settle();
   endtask

   task automatic t_reset();
      chk("R13 ee", AW'(ee), 1); chk("R13 eip", AW'(eip), 0);
      chk("R13 um/vm", AW'({um, vm, ums, vms}), 0);
      chk("R13 cause", AW'(esr_cause), 0); chk("R13 ds", AW'(esr_ds), 0);
      chk("R13 btr", btr, 0); chk("R13 flush", AW'(flush), 0);
   endtask

   task automatic t_plain_illegal();
      fault(10'b1, 32'h0000_1000, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 strobes", AW'({flush, kill, rd_valid, link_we}), 4'hF);
      chk("R2 vector", rd_pc, VEC);
      chk("R3 link", link_val, 32'h0000_1004);
      settle();
      chk("R7 cause", AW'(esr_cause), 1);
      chk("R8 eip/ee", AW'({eip, ee}), 2'b10);
      chk("R6 ds clear", AW'(esr_ds), 0);
   endtask

   task automatic t_ignore_in_progress();
      fault(10'b100, 32'h0000_2000, 0, 0, 0, 0, 0, 0, 0);
      chk("R1 blocked eip", AW'({flush, link_we}), 0);
      settle();
      chk("R1 cause kept", AW'(esr_cause), 1);
   endtask

   task automatic t_trap_return();
      do_ret(2'd1);
      chk("R9 ee/eip", AW'({ee, eip}), 2'b10);
   endtask

   task automatic t_ds_nonmmu();
      do_wr(1, 1, 1);
      chk("R12 write", AW'({ee, um, vm}), 3'b111);
      fault(10'b1000, 32'h0000_3008, 0, 0, 1, 32'h0000_3004, 0, 0, 32'h0000_8800);
      chk("R3 link ds", link_val, 32'h0000_300C);
      settle();
      chk("R6 ds set", AW'(esr_ds), 1);
      chk("R6 btr", btr, 32'h0000_8800);
      chk("R7 unalign", AW'(esr_cause), 4);
      chk("R8 save", AW'({ums, vms, um, vm}), 4'b1100);
   endtask

   task automatic t_break_return();
      do_ret(2'd2);
      chk("R10 brk modes", AW'({um, vm}), 2'b11);
      chk("R10 brk ee/eip", AW'({ee, eip}), 2'b01);
      fault(10'b1, 32'h40, 0, 0, 0, 0, 0, 0, 0);
      chk("R1 still blocked", AW'(flush), 0);
      settle();
      do_ret(2'd1);
      chk("R9 modes", AW'({um, vm, ee, eip}), 4'b1110);
   endtask

   task automatic t_mmu_cases();
      fault(10'b1_0000_0000, 32'h0000_5000, 0, 0, 0, 0, 0, 0, 0);
      chk("R4 link pc", link_val, 32'h0000_5000);
      settle();
      chk("R7 dtlb", AW'(esr_cause), 9);
      do_ret(2'd1);
      fault(10'b10_0000_0000, 32'h0000_5104, 1, 32'h0000_5100, 0, 0, 0, 0, 0);
      chk("R4 link pfx", link_val, 32'h0000_5100);
      settle();
      do_ret(2'd1);
      fault(10'b100_0000, 32'h0000_6008, 0, 0, 1, 32'h0000_6004, 0, 0, 32'h9999_0000);
      chk("R5 link br", link_val, 32'h0000_6004);
      settle();
      chk("R5 ds clear", AW'(esr_ds), 0);
      chk("R6 btr held", btr, 32'h0000_8800);
      do_ret(2'd1);
      fault(10'b1000_0000, 32'h0000_700C, 0, 0, 1, 32'h0000_7008, 1, 32'h0000_7004, 0);
      chk("R5 link br pfx", link_val, 32'h0000_7004);
      settle();
      chk("R7 istore", AW'(esr_cause), 8);
      do_ret(2'd1);
   endtask

   task automatic t_priority();
      fault(10'b1_0000_0100, 32'h0000_A000, 0, 0, 0, 0, 0, 0, 0);
      chk("R7 prio link", link_val, 32'h0000_A004);
      settle();
      chk("R7 prio cause", AW'(esr_cause), 3);
      do_ret(2'd1);
   endtask

   task automatic t_gating();
      fault(10'b1_0000, 32'h0000_B000, 0, 0, 0, 0, 0, 0, 0);
      chk("R11 div off", AW'(flush), 0);
      settle();
      chk("R11 div no state", AW'({eip, esr_cause}), 3);
      fault(10'b10_0000, 32'h0000_B100, 0, 0, 0, 0, 0, 0, 0);
      chk("R11 fpu on", AW'(flush), 1);
      settle();
      chk("R11 fpu cause", AW'(esr_cause), 6);
      do_ret(2'd3);
      chk("R10 int ee/eip", AW'({ee, eip}), 2'b01);
      do_ret(2'd1);
   endtask

   task automatic t_disabled_and_invalid();
      @(negedge clk); flt = 10'b1; ex_valid = 1'b0; #2;
      chk("R1 no valid", AW'(flush), 0);
      settle();
      do_wr(0, 0, 0);
      fault(10'b1, 32'h0000_C000, 0, 0, 0, 0, 0, 0, 0);
      chk("R1 ee clear", AW'(flush), 0);
      settle();
      chk("R1 eip stays", AW'(eip), 0);
      // trap beats a same-cycle return; return beats write
      do_wr(1, 0, 0);
      @(negedge clk);
      flt = 10'b1; ex_valid = 1'b1; ex_pc = 32'h0000_D000; ret_kind = 2'd1;
      st_wr = 1'b1; st_ee = 1'b1; st_um = 1'b1; st_vm = 1'b1;
      settle();
      chk("R12 trap wins", AW'({ee, eip, um}), 3'b010);
      @(negedge clk); ret_kind = 2'd1; st_wr = 1'b1; st_ee = 1'b0; settle();
      chk("R12 return wins", AW'({ee, eip}), 2'b10);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      t_reset();
      t_plain_illegal();
      t_ignore_in_progress();
      t_trap_return();
      t_ds_nonmmu();
      t_break_return();
      t_mmu_cases();
      t_priority();
      t_gating();
      t_disabled_and_invalid();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule